// File: doc/BRIEF.md
# Associative Storage Module Mapper

This block turns the addresses a processor issues into a physical storage module and a word position in that module. The program number of the running path is placed above its 14-bit program address to form a 19-bit system address. The upper 11 bits of that address form a tag. The tag is compared at once against every entry of an associative table. The table has one entry per installed 256-word module. A matching entry gives the module index, which is the position of that entry. The low 8 bits pass through unchanged as the word offset.

Each processor has its own lookup port and its own copy of the table. One shared maintenance port lets the executive assign a module to a program by writing a tag into an entry. The write lands in every processor's copy in the same clock edge, so storage is handed out without moving any data. A free command withdraws the entry. Modules have no order or adjacency, and programs never share a module. Because the program number is part of every tag, a path can only reach modules that carry its own number. Any other address finds no entry and is reported as an access fault.

Top module: `amm_mapper`

## Requirements
- R1: For each processor, the tag is {program number (5 bits), program address bits 13..8} (11 bits), and word_off_o equals program address bits 7..0 on every lookup, hit or miss.
- R2: A write with an entry index below N_MOD stores the tag in that entry and marks it valid. From the next clock edge on, a lookup with that tag gives hit_o=1 and mod_idx_o equal to the entry index.
- R3: The lookup is combinational: hit_o, fault_o, mod_idx_o and word_off_o follow the lookup inputs in the same cycle, with no clock edge between them.
- R4: A lookup whose tag matches no valid entry gives hit_o=0, fault_o=1 and mod_idx_o=0. When hit_o=1, fault_o is 0.
- R5: A free command with an entry index below N_MOD clears that entry's valid bit. From the next edge on, lookups of its tag no longer select it.
- R6: Every write and free updates all processors' tables in the same clock edge, and every processor's lookup gives the same result for the same tag.
- R7: A write or free whose entry index is N_MOD or higher leaves every table unchanged.
- R8: When a write and a free name the same entry in one cycle, the free wins and the entry ends invalid. When they name different entries, both take effect.
- R9: If several valid entries hold the same tag, the lowest entry index is reported.
- R10: The same program address issued under a different program number maps only to a module whose tag carries that number. Otherwise it faults. Program number 0 (the executive) translates like any other number.
- R11: Reset (rst_ni low) clears every valid bit, so every lookup faults until a module is written.
- R12: Writing a new tag into a valid entry replaces its old tag: the old tag then faults and the new tag hits that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_prog_i | input | N_PROC*PROG_W | Program number per processor, processor p at bits [p*PROG_W +: PROG_W] |
| lk_addr_i | input | N_PROC*ADDR_W | Program address per processor, processor p at bits [p*ADDR_W +: ADDR_W] |
| hit_o | output | N_PROC | Lookup found a valid matching entry |
| fault_o | output | N_PROC | Lookup found no entry (access fault) |
| mod_idx_o | output | N_PROC*IDX_W | Selected module index, 0 on fault |
| word_off_o | output | N_PROC*WORD_W | Word offset inside the module |
| wr_en_i | input | 1 | Write a tag into one entry of every table |
| wr_idx_i | input | IDX_W | Entry index for the write |
| wr_tag_i | input | TAG_W | Tag to store |
| free_en_i | input | 1 | Clear the valid bit of one entry in every table |
| free_idx_i | input | IDX_W | Entry index for the free |

## Verification
Lookup results are due in the cycle the lookup inputs are applied. The bench therefore drives lookups on the falling edge, and a monitor compares the queued expectation a short delay later, before the next rising edge. A write or free is held across exactly one rising edge. Its effect is first expected in the lookup driven at the following falling edge, so no check looks at a table before the edge that updates it. Every lookup is repeated on each processor's port wherever R6 is claimed.

// File: rtl/amm_pkg.sv
package amm_pkg;
  localparam int PROG_W_D = 5;
  localparam int ADDR_W_D = 14;
  localparam int WORD_W_D = 8;
  localparam int N_MOD_D  = 100;
  localparam int N_PROC_D = 2;
endpackage

// File: rtl/amm_addr_split.sv
module amm_addr_split #(
  parameter int PROG_W = amm_pkg::PROG_W_D,
  parameter int ADDR_W = amm_pkg::ADDR_W_D,
  parameter int WORD_W = amm_pkg::WORD_W_D,
  localparam int TAG_W = PROG_W + ADDR_W - WORD_W
) (
  input  logic [PROG_W-1:0] prog_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [WORD_W-1:0] off_o
);
  logic [PROG_W+ADDR_W-1:0] sys_addr;

  assign sys_addr = {prog_i, addr_i};
  assign tag_o    = sys_addr[PROG_W+ADDR_W-1:WORD_W];
  assign off_o    = sys_addr[WORD_W-1:0];
endmodule

// File: rtl/amm_table.sv
module amm_table #(
  parameter int N_MOD = amm_pkg::N_MOD_D,
  parameter int TAG_W = 11,
  localparam int IDX_W = $clog2(N_MOD)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic [TAG_W-1:0]             wr_tag_i,
  input  logic                         free_en_i,
  input  logic [IDX_W-1:0]             free_idx_i,
  output logic [N_MOD-1:0]             valid_o,
  output logic [N_MOD-1:0][TAG_W-1:0]  tag_o
);
  localparam logic [IDX_W:0] N_MOD_L = (IDX_W+1)'(N_MOD);

  logic [N_MOD-1:0]            valid_q;
  logic [N_MOD-1:0][TAG_W-1:0] tag_q;
  logic                        wr_ok, free_ok;

  assign wr_ok   = wr_en_i   && ({1'b0, wr_idx_i}   < N_MOD_L);
  assign free_ok = free_en_i && ({1'b0, free_idx_i} < N_MOD_L);

  // free is applied last so it wins over a same-entry write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else begin
      if (wr_ok) begin
        valid_q[wr_idx_i] <= 1'b1;
        tag_q[wr_idx_i]   <= wr_tag_i;
      end
      if (free_ok) valid_q[free_idx_i] <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;

  p_write_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && !(free_ok && free_idx_i == wr_idx_i))
    |=> (valid_q[$past(wr_idx_i)] && tag_q[$past(wr_idx_i)] == $past(wr_tag_i)));

  p_free_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_ok |=> !valid_q[$past(free_idx_i)]);

  p_oob_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ok && !free_ok) |=> ($stable(valid_q) && $stable(tag_q)));
endmodule

// File: rtl/amm_match.sv
module amm_match #(
  parameter int N_MOD = amm_pkg::N_MOD_D,
  parameter int TAG_W = 11,
  localparam int IDX_W = $clog2(N_MOD)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_MOD-1:0]            valid_i,
  input  logic [N_MOD-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]            lk_tag_i,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            idx_o
);
  logic [N_MOD-1:0] match;

  for (genvar e = 0; e < N_MOD; e++) begin : g_cmp
    assign match[e] = valid_i[e] && (tag_i[e] == lk_tag_i);
  end

  // descending scan: lowest matching entry is written last
  always_comb begin
    idx_o = '0;
    for (int e = N_MOD - 1; e >= 0; e--) begin
      if (match[e]) idx_o = IDX_W'(e);
    end
  end

  assign hit_o = |match;

  p_hit_is_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (valid_i[idx_o] && tag_i[idx_o] == lk_tag_i));
endmodule

// File: rtl/amm_mapper.sv
module amm_mapper #(
  parameter int PROG_W = amm_pkg::PROG_W_D,
  parameter int ADDR_W = amm_pkg::ADDR_W_D,
  parameter int WORD_W = amm_pkg::WORD_W_D,
  parameter int N_MOD  = amm_pkg::N_MOD_D,
  parameter int N_PROC = amm_pkg::N_PROC_D,
  localparam int TAG_W = PROG_W + ADDR_W - WORD_W,
  localparam int IDX_W = $clog2(N_MOD)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_PROC*PROG_W-1:0]   lk_prog_i,
  input  logic [N_PROC*ADDR_W-1:0]   lk_addr_i,
  output logic [N_PROC-1:0]          hit_o,
  output logic [N_PROC-1:0]          fault_o,
  output logic [N_PROC*IDX_W-1:0]    mod_idx_o,
  output logic [N_PROC*WORD_W-1:0]   word_off_o,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [TAG_W-1:0]           wr_tag_i,
  input  logic                       free_en_i,
  input  logic [IDX_W-1:0]           free_idx_i
);
  logic [N_PROC-1:0][N_MOD-1:0]            valid_all;
  logic [N_PROC-1:0][N_MOD-1:0][TAG_W-1:0] tag_all;
  logic [N_PROC-1:0][TAG_W-1:0]            lk_tag;

  for (genvar p = 0; p < N_PROC; p++) begin : g_proc
    amm_addr_split #(.PROG_W(PROG_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_split (
      .prog_i (lk_prog_i[p*PROG_W +: PROG_W]),
      .addr_i (lk_addr_i[p*ADDR_W +: ADDR_W]),
      .tag_o  (lk_tag[p]),
      .off_o  (word_off_o[p*WORD_W +: WORD_W])
    );

    // each processor owns a copy; all copies share one write port
    amm_table #(.N_MOD(N_MOD), .TAG_W(TAG_W)) u_table (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .wr_idx_i   (wr_idx_i),
      .wr_tag_i   (wr_tag_i),
      .free_en_i  (free_en_i),
      .free_idx_i (free_idx_i),
      .valid_o    (valid_all[p]),
      .tag_o      (tag_all[p])
    );

    amm_match #(.N_MOD(N_MOD), .TAG_W(TAG_W)) u_match (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (valid_all[p]),
      .tag_i    (tag_all[p]),
      .lk_tag_i (lk_tag[p]),
      .hit_o    (hit_o[p]),
      .idx_o    (mod_idx_o[p*IDX_W +: IDX_W])
    );

    assign fault_o[p] = !hit_o[p];

    p_fault_no_select_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o[p] |-> (mod_idx_o[p*IDX_W +: IDX_W] == '0));

    if (p > 0) begin : g_agree
      p_tables_agree_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_all[p] == valid_all[0]) && (tag_all[p] == tag_all[0]));
    end
  end
endmodule

// File: tb/amm_mapper_tb.sv
module amm_mapper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_W = 5;
  localparam int ADDR_W = 14;
  localparam int WORD_W = 8;
  localparam int N_MOD  = 100;
  localparam int N_PROC = 2;
  localparam int TAG_W  = 11;
  localparam int IDX_W  = 7;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N_PROC*PROG_W-1:0] lk_prog = '0;
  logic [N_PROC*ADDR_W-1:0] lk_addr = '0;
  logic [N_PROC-1:0]        hit, fault;
  logic [N_PROC*IDX_W-1:0]  mod_idx;
  logic [N_PROC*WORD_W-1:0] word_off;
  logic                     wr_en = 1'b0, free_en = 1'b0;
  logic [IDX_W-1:0]         wr_idx = '0, free_idx = '0;
  logic [TAG_W-1:0]         wr_tag = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int          proc;
    logic        hit;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] off;
    string       req;
  } exp_t;

  exp_t sb_q[$];
  event lk_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  amm_mapper u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_prog_i(lk_prog), .lk_addr_i(lk_addr),
    .hit_o(hit), .fault_o(fault), .mod_idx_o(mod_idx), .word_off_o(word_off),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tag_i(wr_tag),
    .free_en_i(free_en), .free_idx_i(free_idx)
  );

  // monitor: result is combinational (R3), sampled 2 units after the drive
  initial begin
    forever begin
      @(lk_ev);
      #2;
      while (sb_q.size() > 0) begin
        exp_t e;
        logic a_hit, a_fault;
        logic [IDX_W-1:0] a_idx;
        logic [WORD_W-1:0] a_off;
        e = sb_q.pop_front();
        a_hit   = hit[e.proc];
        a_fault = fault[e.proc];
        a_idx   = mod_idx[e.proc*IDX_W +: IDX_W];
        a_off   = word_off[e.proc*WORD_W +: WORD_W];
        checks++;
        if (a_hit !== e.hit || a_fault !== !e.hit || a_idx !== e.idx || a_off !== e.off) begin
          failures++;
          $display("FAIL %s proc%0d: hit=%b fault=%b idx=%0d off=%h expected hit=%b fault=%b idx=%0d off=%h",
                   e.req, e.proc, a_hit, a_fault, a_idx, a_off, e.hit, !e.hit, e.idx, e.off);
        end
      end
    end
  end

  task automatic lookup(input int p, input logic [PROG_W-1:0] prog, input logic [ADDR_W-1:0] addr,
                        input logic exp_hit, input int exp_idx, input string req);
    exp_t e;
    @(negedge clk);
    lk_prog[p*PROG_W +: PROG_W] = prog;
    lk_addr[p*ADDR_W +: ADDR_W] = addr;
    e.proc = p;
    e.hit  = exp_hit;
    e.idx  = exp_hit ? IDX_W'(exp_idx) : '0;
    e.off  = addr[WORD_W-1:0];
    e.req  = req;
    sb_q.push_back(e);
    -> lk_ev;
  endtask

  task automatic lookup_all(input logic [PROG_W-1:0] prog, input logic [ADDR_W-1:0] addr,
                            input logic exp_hit, input int exp_idx, input string req);
    for (int p = 0; p < N_PROC; p++) lookup(p, prog, addr, exp_hit, exp_idx, req);
  endtask

  task automatic maint(input logic we, input int widx, input logic [TAG_W-1:0] tag,
                       input logic fe, input int fidx);
    @(negedge clk);
    wr_en = we; wr_idx = IDX_W'(widx); wr_tag = tag;
    free_en = fe; free_idx = IDX_W'(fidx);
    @(negedge clk);
    wr_en = 1'b0; free_en = 1'b0;
  endtask

  function automatic logic [TAG_W-1:0] mk_tag(input int prog, input int page);
    return TAG_W'((prog << 6) | page);
  endfunction

  initial begin
    // R11: reset clears all entries
    lookup_all(5'd3, 14'h0105, 1'b0, 0, "R11");
    @(negedge clk); rst_ni = 1'b1;
    lookup_all(5'd0, 14'h0000, 1'b0, 0, "R11");

    // R2 R1 R6: write entry 5, seen on every processor
    maint(1, 5, mk_tag(3, 1), 0, 0);
    lookup_all(5'd3, 14'h0142, 1'b1, 5, "R2_R1_R6");
    // R4 R1: miss keeps the offset
    lookup(0, 5'd3, 14'h0242, 1'b0, 0, "R4_R1");
    // R10: same address, other program
    lookup_all(5'd4, 14'h0142, 1'b0, 0, "R10");

    // boundary entries 99 and 0; R10 executive program 0
    maint(1, 99, mk_tag(4, 1), 0, 0);
    lookup_all(5'd4, 14'h01FF, 1'b1, 99, "R2_R10");
    maint(1, 0, mk_tag(0, 63), 0, 0);
    lookup_all(5'd0, 14'h3F00, 1'b1, 0, "R10_R2");

    // R7: indices at and past N_MOD ignored
    maint(1, 100, mk_tag(7, 0), 0, 0);
    lookup_all(5'd7, 14'h0000, 1'b0, 0, "R7");
    maint(1, 127, mk_tag(7, 0), 0, 0);
    lookup(1, 5'd7, 14'h0010, 1'b0, 0, "R7");
    maint(0, 0, '0, 1, 120);
    lookup(0, 5'd0, 14'h3F00, 1'b1, 0, "R7");

    // R9: duplicate tag, lowest index wins
    maint(1, 20, mk_tag(3, 1), 0, 0);
    lookup_all(5'd3, 14'h0177, 1'b1, 5, "R9");
    // R5: free entry 5 leaves entry 20
    maint(0, 0, '0, 1, 5);
    lookup_all(5'd3, 14'h0177, 1'b1, 20, "R5_R9");
    maint(0, 0, '0, 1, 20);
    lookup_all(5'd3, 14'h0177, 1'b0, 0, "R5");

    // R12: retag entry 99
    maint(1, 99, mk_tag(4, 2), 0, 0);
    lookup(0, 5'd4, 14'h0101, 1'b0, 0, "R12");
    lookup_all(5'd4, 14'h0200, 1'b1, 99, "R12");

    // R8: same-entry write and free, free wins
    maint(1, 30, mk_tag(9, 0), 1, 30);
    lookup_all(5'd9, 14'h0000, 1'b0, 0, "R8");
    // R8: different entries, both apply
    maint(1, 31, mk_tag(9, 1), 1, 0);
    lookup_all(5'd9, 14'h0100, 1'b1, 31, "R8");
    lookup_all(5'd0, 14'h3F00, 1'b0, 0, "R8");

    // R3: input change alone updates output within the cycle
    lookup(1, 5'd4, 14'h02AB, 1'b1, 99, "R3");
    lookup(1, 5'd4, 14'h03AB, 1'b0, 0, "R3");

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule